// File: doc/BRIEF.md
# Six-Step Motor Output Channel Manager

This block drives the six gate-control outputs of a three-phase bridge. Channels 0 to 2 are the high-side switches of phases A, B and C; channels 3 to 5 are the low-side switches of the same phases. Software writes a staging register with the set of channels to switch on in the next commutation step and with the way the PWM signal should be routed. That staged value becomes active only when the commutation pulse arrives, so software may prepare the next step at any time without disturbing the current one.

The active configuration decides which channels are on and where the PWM lands. The PWM can go to the high group only, to the low group only, to both groups at once, or to the two groups in turn on successive PWM periods. A per-channel polarity mask adapts each output to the sense of its gate driver. The output enables drop to high impedance whenever software clears the enable bit, and at once, with no clock, while the emergency-stop input is low. The PWM source and the pad buffers sit outside the block; it only supplies a data bit and an output enable per channel.

A typical sequence walks through six patterns, one per step: A+/B-, A+/C-, B+/C-, B+/A-, C+/A-, C+/B-. Each pattern has one high-side channel and one low-side channel on.

Top module: `motor_chan_mgr`

## Requirements
- R1: After reset, the enable bit and the active pattern are both clear, so every `chanOe` bit is 0. Enabling the outputs without a commutation then shows every channel at its off level.
- R2: Register writes use `wrSel`. 0 stages the next step, with `wrData[5:0]` as the channel-on mask and `wrData[7:6]` as the route. 1 loads the polarity mask from `wrData[5:0]`. 2 loads the enable bit from `wrData[0]`. 3 has no effect. The staged step does not change any output until `commPulse` is sampled high.
- R3: On a clock edge with `commPulse` high, the staged mask and route become active and appear on the outputs in the cycle that follows. A staging write made on that same edge is kept for the next commutation and is not the value made active.
- R4: Route 0 (high): an active high-side channel drives `pwmIn`, and an active low-side channel is steadily on.
- R5: Route 1 (low): an active low-side channel drives `pwmIn`, and an active high-side channel is steadily on.
- R6: Route 2 (both, simultaneous): every active channel drives `pwmIn`.
- R7: Route 3 (alternate): PWM periods are counted from reset by pulses on `periodStart`. In an even period the high group takes `pwmIn` and the low group is steadily on. In an odd period the roles swap. The new period starts in the cycle after the pulse.
- R8: Each `chanOut` bit equals its channel's logical level XOR its polarity bit: 1 when on, 0 when off. This also applies to inactive channels.
- R9: While the enable bit is 0, all six `chanOe` bits are 0. While it is 1 and `estopN` is high, all six are 1.
- R10: While `estopN` is low, all `chanOe` bits are 0 without waiting for a clock edge. All stored state is kept, so the outputs come back unchanged when `estopN` returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 2 | Register select for the write |
| wrData | input | 8 | Write data |
| commPulse | input | 1 | Commutation pulse; makes the staged step active |
| periodStart | input | 1 | Pulse marking the start of a PWM period |
| pwmIn | input | 1 | PWM signal to be routed |
| estopN | input | 1 | Emergency stop, active low, acts without a clock |
| chanOut | output | 6 | Per-channel drive level after polarity |
| chanOe | output | 6 | Per-channel output enable, 1 = driven |

## Verification
Register writes, commutations and period pulses take effect on the clock edge that samples them. Their results are visible on the outputs from that edge on. `pwmIn` and `estopN` reach the outputs through logic alone, in the same cycle. The bench changes its inputs 1 ns after a rising edge and compares the outputs 1 ns later, so every registered result is checked in the cycle right after its edge. The emergency stop and PWM are checked between edges, with no clock edge in between.

// File: rtl/mcm_pkg.sv
package mcm_pkg;
  typedef enum logic [1:0] {
    ROUTE_HIGH = 2'd0,
    ROUTE_LOW  = 2'd1,
    ROUTE_BOTH = 2'd2,
    ROUTE_ALT  = 2'd3
  } route_e;

  typedef enum logic [1:0] {
    SEL_STEP = 2'd0,
    SEL_POL  = 2'd1,
    SEL_EN   = 2'd2,
    SEL_NONE = 2'd3
  } sel_e;

  typedef struct packed {
    logic loadStep;
    logic loadPol;
    logic loadEn;
    logic commit;
    logic altPhase;
  } strobe_t;
endpackage

// File: rtl/mcm_ctrl.sv
module mcm_ctrl
  import mcm_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    wrEn,
  input  logic [1:0] wrSel,
  input  logic    commPulse,
  input  logic    periodStart,
  output strobe_t strobes
);
  logic phaseQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phaseQ <= 1'b0;
    else if (periodStart) phaseQ <= ~phaseQ;
  end

  always_comb begin
    strobes          = '0;
    strobes.loadStep = wrEn && (sel_e'(wrSel) == SEL_STEP);
    strobes.loadPol  = wrEn && (sel_e'(wrSel) == SEL_POL);
    strobes.loadEn   = wrEn && (sel_e'(wrSel) == SEL_EN);
    strobes.commit   = commPulse;
    strobes.altPhase = phaseQ;
  end
endmodule

// File: rtl/mcm_dpath.sv
module mcm_dpath
  import mcm_pkg::*;
#(
  parameter int GROUP = 3,
  parameter int DW    = 8,
  localparam int NCH  = 2 * GROUP
) (
  input  logic           clk,
  input  logic           rstN,
  input  strobe_t        strobes,
  input  logic [DW-1:0]  wrData,
  input  logic           pwmIn,
  input  logic           estopN,
  output logic [NCH-1:0] chanOut,
  output logic [NCH-1:0] chanOe,
  output logic [NCH-1:0] preMask,
  output logic [NCH-1:0] activeMask,
  output logic [NCH-1:0] polMask,
  output logic           enBit
);
  route_e preRoute, activeRoute;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preMask     <= '0;
      preRoute    <= ROUTE_HIGH;
      activeMask  <= '0;
      activeRoute <= ROUTE_HIGH;
      polMask     <= '0;
      enBit       <= 1'b0;
    end else begin
      if (strobes.commit) begin
        activeMask  <= preMask;
        activeRoute <= preRoute;
      end
      if (strobes.loadStep) begin
        preMask  <= wrData[NCH-1:0];
        preRoute <= route_e'(wrData[DW-1:DW-2]);
      end
      if (strobes.loadPol) polMask <= wrData[NCH-1:0];
      if (strobes.loadEn)  enBit   <= wrData[0];
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    localparam bit IS_HIGH = (i < GROUP);
    logic pwmHere;
    logic level;
    always_comb begin
      unique case (activeRoute)
        ROUTE_HIGH: pwmHere = IS_HIGH;
        ROUTE_LOW:  pwmHere = !IS_HIGH;
        ROUTE_BOTH: pwmHere = 1'b1;
        default:    pwmHere = IS_HIGH ? !strobes.altPhase : strobes.altPhase;
      endcase
      level      = activeMask[i] & (pwmHere ? pwmIn : 1'b1);
      chanOut[i] = level ^ polMask[i];
      chanOe[i]  = enBit & estopN;
    end
  end
endmodule

// File: rtl/motor_chan_mgr.sv
module motor_chan_mgr
  import mcm_pkg::*;
#(
  parameter int GROUP = 3,
  parameter int DW    = 8,
  localparam int NCH  = 2 * GROUP
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           wrEn,
  input  logic [1:0]     wrSel,
  input  logic [DW-1:0]  wrData,
  input  logic           commPulse,
  input  logic           periodStart,
  input  logic           pwmIn,
  input  logic           estopN,
  output logic [NCH-1:0] chanOut,
  output logic [NCH-1:0] chanOe
);
  strobe_t        strobes;
  logic [NCH-1:0] preMask, activeMask, polMask;
  logic           enBit;

  mcm_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel),
    .commPulse(commPulse), .periodStart(periodStart), .strobes(strobes)
  );

  mcm_dpath #(.GROUP(GROUP), .DW(DW)) u_dpath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(wrData),
    .pwmIn(pwmIn), .estopN(estopN), .chanOut(chanOut), .chanOe(chanOe),
    .preMask(preMask), .activeMask(activeMask), .polMask(polMask), .enBit(enBit)
  );
endmodule

// File: rtl/mcm_checker.sv
module mcm_checker #(
  parameter int NCH = 6
) (
  input logic           clk,
  input logic           rstN,
  input logic           commPulse,
  input logic           estopN,
  input logic [NCH-1:0] chanOut,
  input logic [NCH-1:0] chanOe,
  input logic [NCH-1:0] preMask,
  input logic [NCH-1:0] activeMask,
  input logic [NCH-1:0] polMask,
  input logic           enBit
);
  // R10
  estop_hiz_chk: assert property (@(posedge clk) disable iff (!rstN)
    !estopN |-> chanOe == '0);

  // R9
  enable_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enBit |-> chanOe == '0);

  // R9
  oe_uniform_chk: assert property (@(posedge clk) disable iff (!rstN)
    (chanOe == '0) || (chanOe == '1));

  // R3
  step_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    commPulse |=> activeMask == $past(preMask));

  // R2
  step_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !commPulse |=> $stable(activeMask));

  // R8
  off_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((chanOut ^ polMask) & ~activeMask) == '0);
endmodule

bind motor_chan_mgr mcm_checker #(.NCH(NCH)) u_chk (
  .clk(clk), .rstN(rstN), .commPulse(commPulse), .estopN(estopN),
  .chanOut(chanOut), .chanOe(chanOe), .preMask(preMask),
  .activeMask(activeMask), .polMask(polMask), .enBit(enBit)
);

// File: tb/motor_chan_mgr_test.sv
`timescale 1ns/1ps
module motor_chan_mgr_test;
  logic       clk = 0, rstN = 0;
  logic       wrEn = 0, commPulse = 0, periodStart = 0, pwmIn = 0, estopN = 1;
  logic [1:0] wrSel = 0;
  logic [7:0] wrData = 0;
  logic [5:0] chanOut, chanOe;
  int checks = 0, errors = 0;
  bit done = 0;

  // model state, built from the requirements
  logic [5:0] mPre = 0, mAct = 0, mPol = 0;
  logic [1:0] mPreRt = 0, mActRt = 0;
  logic       mEn = 0, mPhase = 0;

  always #2 clk = ~clk;

  motor_chan_mgr uut (.clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel),
    .wrData(wrData), .commPulse(commPulse), .periodStart(periodStart),
    .pwmIn(pwmIn), .estopN(estopN), .chanOut(chanOut), .chanOe(chanOe));

  function automatic logic [5:0] expOut();
    logic [5:0] r;
    for (int i = 0; i < 6; i++) begin
      bit hi = (i < 3);
      bit pw;
      case (mActRt)
        2'd0: pw = hi;
        2'd1: pw = !hi;
        2'd2: pw = 1;
        default: pw = hi ? !mPhase : mPhase;
      endcase
      r[i] = (mAct[i] & (pw ? pwmIn : 1'b1)) ^ mPol[i];
    end
    return r;
  endfunction

  task automatic check(string req, logic [5:0] act, logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic checkAll(string req);
    check(req, chanOut, expOut());
    check(req, chanOe, (mEn && estopN) ? 6'h3f : 6'h00);
  endtask

  // one clock with the given inputs, then settle
  task automatic tick(logic we, logic [1:0] sel, logic [7:0] d, logic cp, logic ps);
    wrEn = we; wrSel = sel; wrData = d; commPulse = cp; periodStart = ps;
    @(posedge clk);
    if (cp) begin mAct = mPre; mActRt = mPreRt; end
    if (we && sel == 0) begin mPre = d[5:0]; mPreRt = d[7:6]; end
    if (we && sel == 1) mPol = d[5:0];
    if (we && sel == 2) mEn = d[0];
    if (ps) mPhase = ~mPhase;
    #1;
    wrEn = 0; commPulse = 0; periodStart = 0;
    #1;
  endtask

  function automatic logic [5:0] stepMask(int k);
    int hiIdx[6] = '{0, 0, 1, 1, 2, 2};
    int loIdx[6] = '{1, 2, 2, 0, 0, 1};
    return 6'(1 << hiIdx[k]) | 6'(1 << (3 + loIdx[k]));
  endfunction

  initial begin
    #100000;
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    done = 1;
  end

  initial begin
    #5; rstN = 1;
    @(posedge clk); #2;
    // R1: reset state
    check("R1", chanOe, 6'h00);
    tick(1, 2, 8'h01, 0, 0);
    check("R1", chanOut, 6'h00);
    check("R1", chanOe, 6'h3f);
    // R2: staging alone changes nothing; select 3 ignored
    tick(1, 0, {2'd0, 6'h3f}, 0, 0);
    check("R2", chanOut, 6'h00);
    tick(1, 3, 8'hff, 0, 0);
    checkAll("R2");
    check("R2", chanOe, 6'h3f);
    // R3: commit with simultaneous staging write
    tick(1, 0, {2'd2, 6'h09}, 1, 0);
    pwmIn = 1; #0.5;
    check("R3", chanOut, 6'h3f);
    tick(0, 0, 0, 1, 0);
    check("R3", chanOut, 6'h09);
    // R4..R8 sweep: routes x steps x polarity x pwm x phase
    for (int rt = 0; rt < 4; rt++)
      for (int k = 0; k < 6; k++)
        for (int p = 0; p < 4; p++) begin
          logic [5:0] pol = (p == 0) ? 6'h00 : (p == 1) ? 6'h3f : (p == 2) ? 6'h15 : 6'h2a;
          tick(1, 1, {2'b0, pol}, 0, 0);
          tick(1, 0, {2'(rt), stepMask(k)}, 0, 0);
          tick(0, 0, 0, 1, (p == 3));
          for (int w = 0; w < 2; w++) begin
            pwmIn = w[0]; #0.5;
            case (rt)
              0: checkAll("R4");
              1: checkAll("R5");
              2: checkAll("R6");
              default: checkAll("R7");
            endcase
            check("R8", chanOut, expOut());
          end
        end
    // R7: explicit alternate phases
    tick(1, 1, 8'h00, 0, 0);
    tick(1, 0, {2'd3, 6'h09}, 1, 0);
    tick(0, 0, 0, 1, 0);
    pwmIn = 0; #0.5;
    check("R7", chanOut, mPhase ? 6'h01 : 6'h08);
    tick(0, 0, 0, 0, 1);
    check("R7", chanOut, mPhase ? 6'h01 : 6'h08);
    // R9: enable off
    tick(1, 2, 8'h00, 0, 0);
    check("R9", chanOe, 6'h00);
    tick(1, 2, 8'h01, 0, 0);
    check("R9", chanOe, 6'h3f);
    // R10: asynchronous emergency stop
    #0.3 estopN = 0; #0.3;
    check("R10", chanOe, 6'h00);
    estopN = 1; #0.3;
    check("R10", chanOe, 6'h3f);
    checkAll("R10");
    done = 1;
  end

  initial begin
    wait (done);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule